// File: doc/BRIEF.md
# Size-Aware Byte-Addressable Memory Slave

This block is a synchronous on-chip memory that sits on a simple 32-bit processor bus. Each bus cycle carries a byte address, a direction bit, a two-bit transfer size code and a sequential-continuation bit. The slave answers only inside its own parameterised address window. It stores whole words and can write single bytes, halfwords or full words without disturbing the bytes around them. A read returns the full stored word one cycle later, and the master then picks out the lanes it asked for.

The slave also polices the bus protocol. From the size code it works out which low address bits to drop, and it reports an access that does not sit on its natural boundary. While a sequential burst is in progress it follows the burst and reports two problems. The first is a change of direction, and such an access is refused. The second is an address that does not follow on from the previous address plus that access's size. Each error is reported on a flag that pulses for one cycle, in the same cycle as the read data slot.

Top module: `sized_mem_slave`

## Requirements
- R1: Only cycles with `bus_req` high and an address in [BASE_ADDR, BASE_ADDR + 4*DEPTH_WORDS) have any effect. Any other cycle leaves storage, burst tracking and `rd_data` unchanged and raises no flag in the following cycle.
- R2: The size codes are 00 for a byte, 01 for a halfword and 10 for a word. Byte lanes are little-endian, with lane k on data bits [8k+7:8k]. A byte access enables lane addr[1:0]. A halfword access enables lanes 1:0 when addr[1] is 0 and lanes 3:2 when addr[1] is 1. A word access enables all four lanes.
- R3: A write changes only the enabled lanes of the addressed word, and each lane takes its byte from its own lane of `wr_data`.
- R4: A performed read drives the whole stored word on `rd_data` in the cycle after the address phase. `rd_data` holds its value in every cycle after which no read was performed.
- R5: A word access ignores addr[1:0] and a halfword access ignores addr[0]. The access is still carried out at the aligned location. When the dropped bits are not zero, `err_align` pulses.
- R6: Size code 11 is reserved. It raises `err_size`, performs no access and ends any active burst.
- R7: A sequential cycle of an active burst whose direction differs from the burst's direction raises `err_dir` and is not performed. The burst state is left as it was.
- R8: A sequential cycle of an active burst whose address differs from the previous accepted address plus that access's byte count raises `err_stride`. The access is still performed, and the next expected address is computed from this cycle's address.
- R9: A non-sequential cycle starts a new burst with no direction or stride check. A sequential cycle when no burst is active also starts one.
- R10: All outputs are zero after reset. Every error flag is a registered one-cycle pulse, and at most one of `err_dir`, `err_stride` and `err_size` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | A transfer is presented this cycle |
| bus_seq | input | 1 | Cycle continues the current burst |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Transfer size code (R2, R6) |
| bus_addr | input | 32 | Byte address |
| wr_data | input | 32 | Write data, replicated across lanes for narrow writes |
| rd_data | output | 32 | Read word, valid the cycle after a read |
| err_align | output | 1 | Pulse: access not naturally aligned |
| err_dir | output | 1 | Pulse: direction changed inside a burst |
| err_stride | output | 1 | Pulse: burst address did not advance by the size |
| err_size | output | 1 | Pulse: reserved size code |

## Verification
The bench aims at the lane edges. These are byte writes to each of the four lanes, halfword writes to both halves, and word writes at addresses offset by 1 to 3. A wrong enable decode would corrupt a neighbouring byte, and a design that honoured the dropped bits would write the wrong word. Bursts are broken on purpose with a direction flip, a skipped address and a reserved size in the middle. A design that let a flipped cycle through would change memory or `rd_data`, and one that did not resync after a stride error would flag the next correct cycle as well. Addresses just outside both ends of the window, and sequential cycles with no open burst, look for a slave that reacts when it should stay silent or checks when it should start a new burst.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam int unsigned BUS_W = 32;
  localparam int unsigned LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    XF_BYTE = 2'b00,
    XF_HALF = 2'b01,
    XF_WORD = 2'b10,
    XF_RSVD = 2'b11
  } xfer_e;

  // Number of bytes moved by one transfer of the given size code.
  function automatic logic [2:0] xfer_bytes(input logic [1:0] sz);
    case (xfer_e'(sz))
      XF_BYTE: xfer_bytes = 3'd1;
      XF_HALF: xfer_bytes = 3'd2;
      XF_WORD: xfer_bytes = 3'd4;
      default: xfer_bytes = 3'd0;
    endcase
  endfunction

  // Little-endian lane enables from size and the two low address bits.
  function automatic logic [LANES-1:0] lane_enable(input logic [1:0] sz,
                                                   input logic [1:0] lo);
    case (xfer_e'(sz))
      XF_BYTE: lane_enable = 4'b0001 << lo;
      XF_HALF: lane_enable = lo[1] ? 4'b1100 : 4'b0011;
      XF_WORD: lane_enable = 4'b1111;
      default: lane_enable = 4'b0000;
    endcase
  endfunction

  // True when the low address bits dropped for this size are not zero.
  function automatic logic off_boundary(input logic [1:0] sz,
                                        input logic [1:0] lo);
    case (xfer_e'(sz))
      XF_HALF: off_boundary = lo[0];
      XF_WORD: off_boundary = |lo;
      default: off_boundary = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/smem_lane_dec.sv
module smem_lane_dec
  import smem_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [1:0]       addr_lo,
  output logic [LANES-1:0] lane_en,
  output logic             misal,
  output logic             size_bad,
  output logic [2:0]       nbytes
);

  always_comb begin
    lane_en  = lane_enable(size, addr_lo);
    misal    = off_boundary(size, addr_lo);
    size_bad = (xfer_e'(size) == XF_RSVD);
    nbytes   = xfer_bytes(size);
  end

endmodule

// File: rtl/smem_burst_chk.sv
module smem_burst_chk
  import smem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             seq,
  input  logic             wr,
  input  logic             size_bad,
  input  logic [2:0]       nbytes,
  input  logic [BUS_W-1:0] addr,
  output logic             dir_err,
  output logic             stride_err
);

  logic             act_q;
  logic             dir_q;
  logic [BUS_W-1:0] next_q;
  logic             cont;

  assign cont       = valid && seq && act_q && !size_bad;
  assign dir_err    = cont && (wr != dir_q);
  assign stride_err = cont && !dir_err && (addr != next_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      next_q <= '0;
    end else if (valid) begin
      if (size_bad) begin
        act_q <= 1'b0;
      end else if (!dir_err) begin
        act_q  <= 1'b1;
        next_q <= addr + {{(BUS_W-3){1'b0}}, nbytes};
        if (!cont) dir_q <= wr;
      end
    end
  end

endmodule

// File: rtl/smem_store.sv
module smem_store
  import smem_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [LANES-1:0] be,
  input  logic [IDX_W-1:0] idx,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);

  logic [BUS_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) begin
        for (int l = 0; l < int'(LANES); l++)
          if (be[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
      end
      if (re) rdata <= mem[idx];
    end
  end

endmodule

// File: rtl/sized_mem_slave.sv
module sized_mem_slave
  import smem_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'h0000_1000,
  parameter int unsigned DEPTH_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_seq,
  input  logic        bus_wr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        err_align,
  output logic        err_dir,
  output logic        err_stride,
  output logic        err_size
);

  localparam int unsigned IDX_W     = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;
  localparam logic [32:0] WIN_BYTES = 33'(DEPTH_WORDS) * 33'd4;

  logic [31:0]      off;
  logic             hit;
  logic             valid;
  logic [LANES-1:0] be;
  logic             misal;
  logic             size_bad;
  logic [2:0]       nbytes;
  logic             dir_err_w;
  logic             stride_err_w;
  logic             go;
  logic             do_write;
  logic             do_read;
  logic [IDX_W-1:0] idx;

  assign off   = bus_addr - BASE_ADDR;
  assign hit   = ({1'b0, off} < WIN_BYTES);
  assign valid = bus_req && hit;
  assign idx   = off[IDX_W+1:2];

  smem_lane_dec u_dec (
    .size    (bus_size),
    .addr_lo (off[1:0]),
    .lane_en (be),
    .misal   (misal),
    .size_bad(size_bad),
    .nbytes  (nbytes)
  );

  smem_burst_chk u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid),
    .seq       (bus_seq),
    .wr        (bus_wr),
    .size_bad  (size_bad),
    .nbytes    (nbytes),
    .addr      (bus_addr),
    .dir_err   (dir_err_w),
    .stride_err(stride_err_w)
  );

  assign go       = valid && !size_bad && !dir_err_w;
  assign do_write = go && bus_wr;
  assign do_read  = go && !bus_wr;

  smem_store #(.DEPTH(DEPTH_WORDS)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (do_write),
    .re   (do_read),
    .be   (be),
    .idx  (idx),
    .wdata(wr_data),
    .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_align  <= 1'b0;
      err_dir    <= 1'b0;
      err_stride <= 1'b0;
      err_size   <= 1'b0;
    end else begin
      err_align  <= go && misal;
      err_dir    <= valid && dir_err_w;
      err_stride <= valid && stride_err_w;
      err_size   <= valid && size_bad;
    end
  end

endmodule

// File: rtl/smem_checker.sv
module smem_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic [1:0]  bus_size,
  input logic        hit,
  input logic [3:0]  be,
  input logic        dir_err_w,
  input logic        stride_err_w,
  input logic        do_write,
  input logic        do_read,
  input logic [31:0] rd_data,
  input logic        err_align,
  input logic        err_dir,
  input logic        err_stride,
  input logic        err_size
);

  a_r6_rsvd_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && hit && bus_size == 2'b11) |-> !(do_write || do_read));

  a_r7_dir_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dir_err_w |-> !(do_write || do_read));

  a_r8_stride_still_done: assert property (@(posedge clk) disable iff (!rst_n)
    stride_err_w |-> (do_write || do_read));

  a_r2_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |-> ($countones(be) == 1 || be == 4'b0011 || be == 4'b1100 || be == 4'b1111));

  a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && hit) |=> !(err_align || err_dir || err_stride || err_size));

  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !do_read |=> $stable(rd_data));

  a_r10_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({err_dir, err_stride, err_size}) <= 1);

endmodule

bind sized_mem_slave smem_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_size    (bus_size),
  .hit         (hit),
  .be          (be),
  .dir_err_w   (dir_err_w),
  .stride_err_w(stride_err_w),
  .do_write    (do_write),
  .do_read     (do_read),
  .rd_data     (rd_data),
  .err_align   (err_align),
  .err_dir     (err_dir),
  .err_stride  (err_stride),
  .err_size    (err_size)
);

// File: tb/sized_mem_slave_test.sv
module sized_mem_slave_test;

  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int DEPTH = 64;
  localparam int WIN   = DEPTH * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_seq = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'b00;
  logic [31:0] bus_addr = '0, wr_data = '0;
  logic [31:0] rd_data;
  logic        err_align, err_dir, err_stride, err_size;

  always #10 clk = ~clk;

  sized_mem_slave #(.BASE_ADDR(BASE), .DEPTH_WORDS(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_seq(bus_seq),
    .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
    .wr_data(wr_data), .rd_data(rd_data), .err_align(err_align),
    .err_dir(err_dir), .err_stride(err_stride), .err_size(err_size));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [7:0]  mb [WIN];
  bit          bact = 0, bwr = 0;
  logic [31:0] bnext = '0;
  logic [31:0] e_rd = '0;
  bit          e_al = 0, e_dir = 0, e_st = 0, e_sz = 0;
  string       prev_tag = "R10";

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk("R4",  {tag, " rd_data"}, rd_data, e_rd);
    chk("R5",  {tag, " err_align"}, 32'(err_align), 32'(e_al));
    chk("R7",  {tag, " err_dir"}, 32'(err_dir), 32'(e_dir));
    chk("R8",  {tag, " err_stride"}, 32'(err_stride), 32'(e_st));
    chk("R6",  {tag, " err_size"}, 32'(err_size), 32'(e_sz));
  endtask

  task automatic model_step();
    int nb, o, b, w;
    bit cont;
    e_al = 0; e_dir = 0; e_st = 0; e_sz = 0;
    if (!bus_req || bus_addr < BASE || bus_addr >= BASE + WIN) return;
    o = int'(bus_addr - BASE);
    if (bus_size == 2'b11) begin
      e_sz = 1; bact = 0; return;
    end
    cont = bus_seq && bact;
    if (cont && (bus_wr != bwr)) begin
      e_dir = 1; return;
    end
    nb = 1 << bus_size;
    if (cont && bus_addr != bnext) e_st = 1;
    if (!cont) bwr = bus_wr;
    bact = 1;
    bnext = bus_addr + nb;
    e_al = (o % nb) != 0;
    b = o - (o % nb);
    if (bus_wr) begin
      for (int k = 0; k < nb; k++) mb[b+k] = wr_data[8*((b+k)%4) +: 8];
    end else begin
      w = o - (o % 4);
      e_rd = {mb[w+3], mb[w+2], mb[w+1], mb[w]};
    end
  endtask

  task automatic cyc(bit r, bit s, bit w, logic [1:0] sz, logic [31:0] a,
                     logic [31:0] d, string tag);
    @(negedge clk);
    compare_all(prev_tag);
    bus_req = r; bus_seq = s; bus_wr = w; bus_size = sz;
    bus_addr = a; wr_data = d;
    model_step();
    prev_tag = tag;
  endtask

  function automatic logic [31:0] rep(logic [1:0] sz, logic [31:0] v);
    if (sz == 2'b00) return {4{v[7:0]}};
    if (sz == 2'b01) return {2{v[15:0]}};
    return v;
  endfunction

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [1:0]  sz;
    logic [31:0] a;
    for (int i = 0; i < WIN; i++) mb[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state checked by the first comparison below
    cyc(0,0,0,2'b00,'0,'0,"R10");
    // R2 R3: byte writes to every lane, then word read
    cyc(1,0,1,2'b00,BASE+0,rep(2'b00,32'h11),"R2");
    cyc(1,0,1,2'b00,BASE+1,rep(2'b00,32'h22),"R2");
    cyc(1,0,1,2'b00,BASE+2,rep(2'b00,32'h33),"R2");
    cyc(1,0,1,2'b00,BASE+3,rep(2'b00,32'h44),"R2");
    cyc(1,0,0,2'b10,BASE+0,'0,"R3");
    // R3: halfword writes to both halves of another word
    cyc(1,0,1,2'b01,BASE+4,rep(2'b01,32'hBEEF),"R3");
    cyc(1,0,0,2'b10,BASE+4,'0,"R3");
    cyc(1,0,1,2'b01,BASE+6,rep(2'b01,32'hCAFE),"R3");
    cyc(1,0,0,2'b10,BASE+4,'0,"R3");
    // R5: misaligned word and halfword go to the aligned location
    cyc(1,0,1,2'b10,BASE+11,32'hA1B2C3D4,"R5");
    cyc(1,0,0,2'b10,BASE+8,'0,"R5");
    cyc(1,0,1,2'b01,BASE+13,rep(2'b01,32'h5566),"R5");
    cyc(1,0,0,2'b00,BASE+13,'0,"R5");
    // R4: idle cycles hold rd_data
    cyc(0,0,0,2'b00,BASE,'0,"R4");
    cyc(1,0,1,2'b10,BASE+16,32'h0F0F0F0F,"R4");
    // R9: word burst of writes then reads
    for (int k = 0; k < 4; k++) cyc(1,k!=0,1,2'b10,BASE+32+4*k,32'h1000+k,"R9");
    for (int k = 0; k < 4; k++) cyc(1,k!=0,0,2'b10,BASE+32+4*k,'0,"R9");
    // R7: direction flip inside a burst is refused
    cyc(1,0,0,2'b10,BASE+48,'0,"R7");
    cyc(1,1,1,2'b10,BASE+52,32'hDEADDEAD,"R7");
    cyc(1,1,0,2'b10,BASE+52,'0,"R7");
    // R8: skipped address, then resync
    cyc(1,0,0,2'b01,BASE+64,'0,"R8");
    cyc(1,1,0,2'b01,BASE+70,'0,"R8");
    cyc(1,1,0,2'b01,BASE+72,'0,"R8");
    // R6: reserved size ends the burst; next seq cycle starts fresh
    cyc(1,0,1,2'b10,BASE+80,32'h77,"R6");
    cyc(1,1,1,2'b11,BASE+84,32'hFFFFFFFF,"R6");
    cyc(1,1,0,2'b10,BASE+80,'0,"R6");
    // R9: seq with no active burst, direction free
    cyc(1,1,1,2'b00,BASE+90,rep(2'b00,32'h9A),"R9");
    // R1: just outside both ends of the window
    cyc(1,0,1,2'b10,BASE-4,32'h12345678,"R1");
    cyc(1,0,1,2'b11,BASE+WIN,32'h12345678,"R1");
    cyc(1,1,0,2'b10,BASE+WIN,'0,"R1");
    cyc(1,0,0,2'b10,BASE+WIN-4,'0,"R1");
    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      sz = ($urandom % 16 == 0) ? 2'b11 : 2'($urandom % 3);
      if ($urandom % 10 < 6 && bact && bnext < BASE + WIN - 4 && $urandom % 8 != 0)
        a = bnext;
      else if ($urandom % 20 == 0)
        a = BASE + WIN + ($urandom % 16);
      else
        a = BASE + ($urandom % WIN);
      cyc(1, $urandom % 10 < 6, ($urandom % 8 < 1) ? !bwr : bwr ^ ($urandom % 4 == 0),
          sz, a, $urandom, "R3");
    end
    cyc(0,0,0,2'b00,'0,'0,"R4");
    cyc(0,0,0,2'b00,'0,'0,"R4");
    finish_run();
  end

endmodule